// File: doc/BRIEF.md
# Two-Way Coherent Tag Directory

This block holds the address tags and per-line coherence states for a small two-way set-associative cache of 16 sets with 256-byte lines (32 lines). A requester presents a 32-bit byte address; in the same cycle the block reports whether the line is present and in which way. It also names the way that would be replaced, with that line's address and state. When the requester asks for an allocation and the lookup misses, the new tag and its coherence state are written into that victim way at the next clock edge. If the victim held modified data, a write-back strobe is raised in the allocating cycle.

Each line's state is one of four enumerated values: invalid (`LS_INV`), shared (`LS_SHR`), exclusive (`LS_EXC`) and modified (`LS_MOD`). There is no separate valid or dirty bit. A line moves between states along these named transitions:
- **reset clear**: every line goes to `LS_INV`.
- **fill**: an allocating miss moves the victim way to the requested state.
- **replace**: the fill lands on a line that is not `LS_INV`.
- **update write**: the separate update port writes any state into a chosen set and way. Writing `LS_INV` drops the line.

Shared and exclusive victims are dropped with no strobe; only a modified victim asks for a write-back. One recency bit per set chooses between two valid ways.

Top module: `coh_tag_dir`

## Requirements
- R1: The set index is address bits [11:8] and the tag is bits [31:12]. Address 0x12345F00 selects set 0xF and 0x12345E00 selects set 0xE.
- R2: `hit` is 1 only when a way of the selected set holds a matching tag in a state other than invalid (2'b00). `hit_way` names that way and is 0 when `hit` is 0. The low 8 address bits do not affect the result.
- R3: After reset every line is invalid: no lookup hits, `vic_state` is 2'b00 and `vic_way` is 0.
- R4: An allocating miss writes the request tag and `req_state` into the victim way at the clock edge. A following lookup of the same line hits in that way.
- R5: When the selected set has an invalid way, that way is the victim, with way 0 before way 1.
- R6: When both ways are valid, the victim is the way used less recently. Each hit and each allocation counts as a use.
- R7: `vic_addr` is the victim's tag, the set index and eight zero bits. `vic_state` is its state, encoded invalid=00, shared=01, exclusive=10, modified=11.
- R8: `wb_req` is 1 in the cycle of an allocating miss whose victim is modified (11). It stays 0 for shared, exclusive or invalid victims and on hits.
- R9: An update writes `upd_state` into line (`upd_set`, `upd_way`) at the clock edge. Writing 00 makes later lookups of that line miss.
- R10: While `upd_valid` is 1, any request in the same cycle is ignored: `hit` and `wb_req` stay 0, nothing is allocated and recency does not change.
- R11: A lookup that misses without `req_alloc` changes neither tags, states nor recency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_alloc | input | 1 | Allocate on miss |
| req_addr | input | 32 | Request byte address |
| req_state | input | 2 | State given to a newly allocated line |
| upd_valid | input | 1 | State update present |
| upd_set | input | 4 | Set to update |
| upd_way | input | 1 | Way to update |
| upd_state | input | 2 | New state for the updated line |
| hit | output | 1 | Request hit |
| hit_way | output | 1 | Way that hit |
| vic_way | output | 1 | Way that would be replaced |
| vic_addr | output | 32 | Line address of the victim |
| vic_state | output | 2 | State of the victim |
| wb_req | output | 1 | Write-back needed for the victim |

## Verification
Two functions can collide in one cycle: a lookup or allocation, and a state update through the update port. The update may even target the very line the request addresses. Random stimulus raises both valids together about one cycle in ten, often on the same few sets. Directed cases pair an allocating miss with an update on an unrelated set. The verdict comes from a bench model: the colliding request must show no hit or strobe, and later lookups must show that only the update took effect.

// File: rtl/coh_dir_pkg.sv
package coh_dir_pkg;

    typedef enum logic [1:0] {
        LS_INV = 2'b00,
        LS_SHR = 2'b01,
        LS_EXC = 2'b10,
        LS_MOD = 2'b11
    } line_state_e;

    localparam int unsigned NUM_WAYS = 2;

endpackage

// File: rtl/coh_dir_store.sv
module coh_dir_store
    import coh_dir_pkg::*;
#(
    parameter int unsigned SETS  = 16,
    parameter int unsigned TAG_W = 20,
    localparam int unsigned IDX_W = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic              fill_way,
    input  logic [TAG_W-1:0]  fill_tag,
    input  line_state_e       fill_state,
    input  logic              upd_en,
    input  logic [IDX_W-1:0]  upd_idx,
    input  logic              upd_way,
    input  line_state_e       upd_state,
    input  logic              lru_en,
    input  logic [IDX_W-1:0]  lru_idx,
    input  logic              lru_val,
    output logic [TAG_W-1:0]  rd_tag   [NUM_WAYS],
    output line_state_e       rd_state [NUM_WAYS],
    output logic              rd_lru
);

    logic [TAG_W-1:0] tag_q [SETS][NUM_WAYS];
    line_state_e      st_q  [SETS][NUM_WAYS];
    logic [SETS-1:0]  lru_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < NUM_WAYS; w++) begin
                    tag_q[s][w] <= '0;
                    st_q[s][w]  <= LS_INV;
                end
            end
            lru_q <= '0;
        end else begin
            if (upd_en) begin
                st_q[upd_idx][upd_way] <= upd_state;
            end else if (fill_en) begin
                tag_q[fill_idx][fill_way] <= fill_tag;
                st_q[fill_idx][fill_way]  <= fill_state;
            end
            if (lru_en) begin
                lru_q[lru_idx] <= lru_val;
            end
        end
    end

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_rd
        assign rd_tag[w]   = tag_q[rd_idx][w];
        assign rd_state[w] = st_q[rd_idx][w];
    end

    assign rd_lru = lru_q[rd_idx];

endmodule

// File: rtl/coh_dir_match.sv
module coh_dir_match
    import coh_dir_pkg::*;
#(
    parameter int unsigned TAG_W = 20
) (
    input  logic [TAG_W-1:0] req_tag,
    input  logic [TAG_W-1:0] way_tag   [NUM_WAYS],
    input  line_state_e      way_state [NUM_WAYS],
    output logic             any_hit,
    output logic             hit_way
);

    logic [NUM_WAYS-1:0] match;

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
        assign match[w] = (way_tag[w] == req_tag) && (way_state[w] != LS_INV);
    end

    assign any_hit = |match;
    assign hit_way = !match[0] && match[1];

endmodule

// File: rtl/coh_dir_victim.sv
module coh_dir_victim
    import coh_dir_pkg::*;
(
    input  line_state_e way_state [NUM_WAYS],
    input  logic        lru,
    output logic        vic_way,
    output line_state_e vic_state,
    output logic        vic_dirty
);

    always_comb begin
        if (way_state[0] == LS_INV) begin
            vic_way = 1'b0;
        end else if (way_state[1] == LS_INV) begin
            vic_way = 1'b1;
        end else begin
            vic_way = lru;
        end
    end

    assign vic_state = way_state[vic_way];

    always_comb begin
        unique case (vic_state)
            LS_MOD:                 vic_dirty = 1'b1;
            LS_EXC, LS_SHR, LS_INV: vic_dirty = 1'b0;
            default:                vic_dirty = 1'b0;
        endcase
    end

endmodule

// File: rtl/coh_tag_dir.sv
module coh_tag_dir
    import coh_dir_pkg::*;
#(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned OFFSET_W = 8,
    parameter int unsigned SETS     = 16,
    localparam int unsigned IDX_W   = $clog2(SETS),
    localparam int unsigned TAG_W   = ADDR_W - IDX_W - OFFSET_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_alloc,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_state,
    input  logic              upd_valid,
    input  logic [IDX_W-1:0]  upd_set,
    input  logic              upd_way,
    input  logic [1:0]        upd_state,
    output logic              hit,
    output logic              hit_way,
    output logic              vic_way,
    output logic [ADDR_W-1:0] vic_addr,
    output logic [1:0]        vic_state,
    output logic              wb_req
);

    logic [IDX_W-1:0] idx;
    logic [TAG_W-1:0] tag;
    logic [TAG_W-1:0] rd_tag   [NUM_WAYS];
    line_state_e      rd_state [NUM_WAYS];
    logic             rd_lru;
    logic             raw_hit, raw_way;
    logic             v_way, v_dirty;
    line_state_e      v_state;
    logic             active, fill_en, lru_en, lru_val;

    assign idx = req_addr[OFFSET_W +: IDX_W];
    assign tag = req_addr[ADDR_W-1 -: TAG_W];

    assign active  = req_valid && !upd_valid;
    assign fill_en = active && req_alloc && !raw_hit;
    assign lru_en  = active && (raw_hit || req_alloc);
    assign lru_val = raw_hit ? !raw_way : !v_way;

    coh_dir_store #(.SETS(SETS), .TAG_W(TAG_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_idx     (idx),
        .fill_en    (fill_en),
        .fill_idx   (idx),
        .fill_way   (v_way),
        .fill_tag   (tag),
        .fill_state (line_state_e'(req_state)),
        .upd_en     (upd_valid),
        .upd_idx    (upd_set),
        .upd_way    (upd_way),
        .upd_state  (line_state_e'(upd_state)),
        .lru_en     (lru_en),
        .lru_idx    (idx),
        .lru_val    (lru_val),
        .rd_tag     (rd_tag),
        .rd_state   (rd_state),
        .rd_lru     (rd_lru)
    );

    coh_dir_match #(.TAG_W(TAG_W)) u_match (
        .req_tag   (tag),
        .way_tag   (rd_tag),
        .way_state (rd_state),
        .any_hit   (raw_hit),
        .hit_way   (raw_way)
    );

    coh_dir_victim u_victim (
        .way_state (rd_state),
        .lru       (rd_lru),
        .vic_way   (v_way),
        .vic_state (v_state),
        .vic_dirty (v_dirty)
    );

    assign hit       = active && raw_hit;
    assign hit_way   = hit && raw_way;
    assign vic_way   = v_way;
    assign vic_addr  = {rd_tag[v_way], idx, {OFFSET_W{1'b0}}};
    assign vic_state = v_state;
    assign wb_req    = fill_en && v_dirty;

endmodule

// File: rtl/coh_tag_dir_chk.sv
module coh_tag_dir_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_alloc,
    input logic [31:0] req_addr,
    input logic [1:0]  req_state,
    input logic        upd_valid,
    input logic        hit,
    input logic        hit_way,
    input logic        vic_way,
    input logic [1:0]  vic_state,
    input logic        wb_req,
    input logic [1:0]  st0,
    input logic [1:0]  st1
);

    AST_WB_ONLY_MODIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> (vic_state == 2'b11 && req_alloc && !hit)); // R8

    AST_UPDATE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> (!hit && !wb_req)); // R10

    AST_INVALID_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (st0 == 2'b00 || st1 == 2'b00) |-> (vic_state == 2'b00)); // R5

    AST_FILL_THEN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !upd_valid && req_alloc && !hit && req_state != 2'b00)
        |=> ((req_valid && !upd_valid && req_addr[31:8] == $past(req_addr[31:8]))
             -> (hit && hit_way == $past(vic_way)))); // R4

    AST_HIT_WAY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> !hit_way); // R2

endmodule

bind coh_tag_dir coh_tag_dir_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_alloc (req_alloc),
    .req_addr  (req_addr),
    .req_state (req_state),
    .upd_valid (upd_valid),
    .hit       (hit),
    .hit_way   (hit_way),
    .vic_way   (vic_way),
    .vic_state (vic_state),
    .wb_req    (wb_req),
    .st0       (rd_state[0]),
    .st1       (rd_state[1])
);

// File: tb/test_coh_tag_dir.sv
module test_coh_tag_dir;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_alloc = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_state = '0;
    logic        upd_valid = 1'b0;
    logic [3:0]  upd_set = '0;
    logic        upd_way = 1'b0;
    logic [1:0]  upd_state = '0;
    logic        hit, hit_way, vic_way, wb_req;
    logic [31:0] vic_addr;
    logic [1:0]  vic_state;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [19:0] mtag [16][2];
    logic [1:0]  mst  [16][2];
    logic        mlru [16];

    logic        s_hit, s_hway, s_vway, s_wb;
    logic [31:0] s_vaddr;
    logic [1:0]  s_vst;

    always #10 clk = ~clk;

    coh_tag_dir i_coh_tag_dir (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_alloc(req_alloc), .req_addr(req_addr), .req_state(req_state),
        .upd_valid(upd_valid), .upd_set(upd_set), .upd_way(upd_way), .upd_state(upd_state),
        .hit(hit), .hit_way(hit_way), .vic_way(vic_way), .vic_addr(vic_addr),
        .vic_state(vic_state), .wb_req(wb_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic rv, input logic ra, input logic [31:0] a, input logic [1:0] rs,
                        input logic uv, input logic [3:0] us, input logic uw, input logic [1:0] ust);
        int s;
        logic [19:0] t;
        logic mh, mw, vw, both;
        req_valid = rv; req_alloc = ra; req_addr = a; req_state = rs;
        upd_valid = uv; upd_set = us; upd_way = uw; upd_state = ust;
        @(negedge clk);
        s = int'(a[11:8]);
        t = a[31:12];
        mh = 1'b0; mw = 1'b0;
        for (int w = 0; w < 2; w++) begin
            if (!mh && mtag[s][w] == t && mst[s][w] != 2'b00) begin
                mh = 1'b1; mw = w[0];
            end
        end
        both = (mst[s][0] != 2'b00) && (mst[s][1] != 2'b00);
        vw = (mst[s][0] == 2'b00) ? 1'b0 : (mst[s][1] == 2'b00) ? 1'b1 : mlru[s];
        s_hit = hit; s_hway = hit_way; s_vway = vic_way; s_vaddr = vic_addr; s_vst = vic_state; s_wb = wb_req;
        chk(uv ? "R10" : "R2", {31'd0, hit}, {31'd0, rv && !uv && mh});
        chk("R2", {31'd0, hit_way}, {31'd0, rv && !uv && mh && mw});
        chk(both ? "R6" : "R5", {31'd0, vic_way}, {31'd0, vw});
        chk("R7", vic_addr, {mtag[s][vw], a[11:8], 8'h00});
        chk("R7", {30'd0, vic_state}, {30'd0, mst[s][vw]});
        chk(uv ? "R10" : "R8", {31'd0, wb_req}, {31'd0, rv && !uv && ra && !mh && mst[s][vw] == 2'b11});
        @(posedge clk);
        #1;
        if (uv) begin
            mst[us][uw] = ust;
        end else if (rv) begin
            if (mh) begin
                mlru[s] = !mw;
            end else if (ra) begin
                mtag[s][vw] = t; mst[s][vw] = rs; mlru[s] = !vw;
            end
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h1f2e3d4c);
        for (int s = 0; s < 16; s++) begin
            for (int w = 0; w < 2; w++) begin
                mtag[s][w] = '0; mst[s][w] = 2'b00;
            end
            mlru[s] = 1'b0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk);
        #1;

        // R3: empty after reset
        step(1, 0, 32'h12345F00, 2'b00, 0, 4'h0, 0, 2'b00);
        chk("R3", {31'd0, s_hit}, 32'd0);
        chk("R3", {30'd0, s_vst}, 32'd0);
        chk("R3", {31'd0, s_vway}, 32'd0);

        // R1: set mapping
        step(1, 1, 32'h12345F00, 2'b10, 0, 4'h0, 0, 2'b00);
        step(1, 1, 32'h12345E00, 2'b11, 0, 4'h0, 0, 2'b00);
        step(1, 0, 32'h12345F80, 2'b00, 0, 4'h0, 0, 2'b00);
        chk("R1", {31'd0, s_hit}, 32'd1);
        step(1, 0, 32'h12345E00, 2'b00, 0, 4'h0, 0, 2'b00);
        chk("R1", {31'd0, s_hit}, 32'd1);
        chk("R1", s_vaddr, 32'h00000E00);

        // R4/R5/R6/R8 on set 3
        step(1, 1, 32'h00001300, 2'b01, 0, 4'h0, 0, 2'b00);
        chk("R5", {31'd0, s_vway}, 32'd0);
        step(1, 0, 32'h000013FF, 2'b00, 0, 4'h0, 0, 2'b00);
        chk("R4", {31'd0, s_hit}, 32'd1);
        chk("R4", {31'd0, s_hway}, 32'd0);
        step(1, 1, 32'h00002300, 2'b11, 0, 4'h0, 0, 2'b00);
        chk("R5", {31'd0, s_vway}, 32'd1);
        step(1, 0, 32'h00002300, 2'b00, 0, 4'h0, 0, 2'b00);
        chk("R4", {31'd0, s_hway}, 32'd1);
        step(1, 1, 32'h00003300, 2'b10, 0, 4'h0, 0, 2'b00);
        chk("R6", {31'd0, s_vway}, 32'd0);
        chk("R8", {31'd0, s_wb}, 32'd0);
        chk("R7", s_vaddr, 32'h00001300);
        step(1, 1, 32'h00004300, 2'b01, 0, 4'h0, 0, 2'b00);
        chk("R6", {31'd0, s_vway}, 32'd1);
        chk("R8", {31'd0, s_wb}, 32'd1);
        chk("R7", s_vaddr, 32'h00002300);
        chk("R7", {30'd0, s_vst}, 32'd3);

        // R9: update drops a line
        step(0, 0, 32'h0, 2'b00, 1, 4'h3, 0, 2'b00);
        step(1, 0, 32'h00003300, 2'b00, 0, 4'h0, 0, 2'b00);
        chk("R9", {31'd0, s_hit}, 32'd0);
        chk("R9", {30'd0, s_vst}, 32'd0);

        // R10: update wins over a colliding allocation
        step(1, 1, 32'h00005300, 2'b10, 1, 4'h9, 1, 2'b01);
        chk("R10", {31'd0, s_wb}, 32'd0);
        step(1, 0, 32'h00005300, 2'b00, 0, 4'h0, 0, 2'b00);
        chk("R10", {31'd0, s_hit}, 32'd0);

        // R11: plain miss keeps recency
        step(1, 1, 32'h00003300, 2'b10, 0, 4'h0, 0, 2'b00);
        step(1, 0, 32'h00007300, 2'b00, 0, 4'h0, 0, 2'b00);
        step(1, 1, 32'h00007300, 2'b10, 0, 4'h0, 0, 2'b00);
        chk("R11", {31'd0, s_vway}, 32'd1);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] a;
            logic [19:0] t;
            logic [3:0]  st;
            case ($urandom % 4)
                0: t = 20'h12345;
                1: t = 20'h12333;
                2: t = 20'hABCDE;
                default: t = 20'h00001;
            endcase
            st = {2'b11, 2'($urandom % 4)} ^ 4'(($urandom % 2) * 12);
            a = {t, st, 8'($urandom)};
            step(($urandom % 4) != 0, $urandom % 2, a, 2'($urandom),
                 ($urandom % 8) == 0, {2'b11, 2'($urandom)} ^ 4'(($urandom % 2) * 12),
                 $urandom % 2, 2'($urandom));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule